// File: doc/BRIEF.md
# Two-Phase Timed Sequence Controller

This controller runs a process as two phases, one strictly after the other, from a single slow tick clock. A small state machine steps from a reset state into phase one, hands off to phase two once phase one has run its full length, and then parks in an end state until reset is applied again. Each phase owns its own tick counter that begins at zero, and while a phase is the active state it drives a group of control lines, each high inside fixed windows of that counter.

Window limits are given in time units, and one unit is `TICKS_PER_UNIT` ticks (50 for a 50 Hz tick). Phase one lasts 18 units and phase two lasts 8 units. A run-enable input pauses both counters without leaving the current phase. Sticky completion flags report that each phase has finished.

Top module: `seq2_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) puts the controller in the reset state, coded `state` = 0, from any state, and clears all control lines, both completion flags and both counters.
- R2: On the first rising edge with `rst` low while in the reset state, the controller enters phase one (`state` = 1) with its counter at zero, whether `run` is high or low.
- R3: A phase counter advances by one on each rising edge where its phase is active and `run` is high. While `run` is low it holds its value, so every window is delayed by the number of paused edges.
- R4: In phase one, with count c and unit U = `TICKS_PER_UNIT`, a line is high when lo*U <= c < hi*U. The windows in units, listed as [lo,hi), are: `p1_out[0]` [1,10), `p1_out[1]` [1,17), `p1_out[2]` [1,9), `p1_out[3]` [11,16), `p1_out[4]` [1,18), `p1_out[5]` [1,5), `p1_out[6]` [1,5). `p1_out[7]` has two windows, [2,9) and [13,17).
- R5: When the phase-one count reaches 18*U, the counter stops. On the next rising edge the controller enters phase two (`state` = 2), `p1_done` rises, and the phase-one counter clears to zero. With `run` held high from reset release, phase two is entered on the 18*U+2-th edge after release.
- R6: The phase-two counter starts at zero on entry to phase two. In phase two, each of `p2_out[2:0]` is high when U <= c < 8*U.
- R7: When the phase-two count reaches 8*U, the counter stops. On the next edge the controller enters the end state (`state` = 3) and `p2_done` rises. The end state, with both flags high, holds until reset. With `run` held high, it is entered on the 26*U+3-th edge after release.
- R8: The `p1_out` lines are all low whenever `state` is not 1. The `p2_out` lines are all low whenever `state` is not 2.
- R9: After a reset in the middle of a run, the next run repeats phase one from count zero, with the same timing as a fresh run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Counting enable for the active phase |
| p1_out | output | 8 | Phase-one timed control lines |
| p2_out | output | 3 | Phase-two timed control lines |
| p1_done | output | 1 | Phase one has completed (sticky until reset) |
| p2_done | output | 1 | Phase two has completed (sticky until reset) |
| state | output | 2 | Current state: 0 reset, 1 phase one, 2 phase two, 3 end |

## Verification
The control lines decode the registered counter directly. Each line therefore reflects a count on the same cycle the count changes, one edge after the `run` value that advanced it. `state` and both completion flags move one edge after the counter sits at its final value, and they follow reset one edge after `rst` is sampled high. The bench changes inputs on falling edges. Its reference model updates on rising edges. It compares every output at each falling edge, so each result is read after the edge that produced it and before the next. Edge counts from reset release to each phase change are checked against the arithmetic totals 18*U+2 and 26*U+3, and against 18*U+1 when counting starts from a paused phase one.

// File: rtl/seq2_pkg.sv
package seq2_pkg;

    typedef enum logic [1:0] {
        ST_RST = 2'd0,
        ST_PH1 = 2'd1,
        ST_PH2 = 2'd2,
        ST_END = 2'd3
    } seq_st_e;

    localparam int unsigned P1_UNITS = 18;
    localparam int unsigned P2_UNITS = 8;
    localparam int unsigned P1_NOUT  = 8;
    localparam int unsigned P2_NOUT  = 3;

    // window limits in units, [lo, hi); a zero-width pair never fires
    localparam int unsigned P1_LO_A [P1_NOUT] = '{1, 1, 1, 11, 1, 1, 1, 2};
    localparam int unsigned P1_HI_A [P1_NOUT] = '{10, 17, 9, 16, 18, 5, 5, 9};
    localparam int unsigned P1_LO_B [P1_NOUT] = '{0, 0, 0, 0, 0, 0, 0, 13};
    localparam int unsigned P1_HI_B [P1_NOUT] = '{0, 0, 0, 0, 0, 0, 0, 17};

    localparam int unsigned P2_LO_A [P2_NOUT] = '{1, 1, 1};
    localparam int unsigned P2_HI_A [P2_NOUT] = '{8, 8, 8};
    localparam int unsigned P2_LO_B [P2_NOUT] = '{0, 0, 0};
    localparam int unsigned P2_HI_B [P2_NOUT] = '{0, 0, 0};

endpackage

// File: rtl/seq2_count.sv
module seq2_count #(
    parameter int unsigned CW    = 10,
    parameter int unsigned FINAL = 900
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          clr,
    output logic [CW-1:0] cnt,
    output logic          last
);

    localparam logic [CW-1:0] LAST_V = CW'(FINAL);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_s;

    cnt_s cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d.cnt = '0;
        end else if (en && (cnt_q.cnt != LAST_V)) begin
            cnt_d.cnt = cnt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt  = cnt_q.cnt;
    assign last = (cnt_q.cnt == LAST_V);

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(cnt_q.cnt));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q.cnt != $past(cnt_q.cnt)) |->
            ((cnt_q.cnt == $past(cnt_q.cnt) + 1'b1) || (cnt_q.cnt == '0)));

    // R5
    cnt_max_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q.cnt <= LAST_V);

endmodule

// File: rtl/seq2_window.sv
module seq2_window #(
    parameter int unsigned NOUT = 1,
    parameter int unsigned TPU  = 1,
    parameter int unsigned CW   = 4,
    parameter int unsigned LO_A [NOUT] = '{default: 0},
    parameter int unsigned HI_A [NOUT] = '{default: 0},
    parameter int unsigned LO_B [NOUT] = '{default: 0},
    parameter int unsigned HI_B [NOUT] = '{default: 0}
) (
    input  logic            active,
    input  logic [CW-1:0]   cnt,
    output logic [NOUT-1:0] win
);

    for (genvar g = 0; g < NOUT; g++) begin : g_line
        localparam logic [CW-1:0] A_LO = CW'(LO_A[g] * TPU);
        localparam logic [CW-1:0] A_HI = CW'(HI_A[g] * TPU);
        localparam logic [CW-1:0] B_LO = CW'(LO_B[g] * TPU);
        localparam logic [CW-1:0] B_HI = CW'(HI_B[g] * TPU);
        logic hit_a;
        logic hit_b;
        assign hit_a  = (cnt >= A_LO) && (cnt < A_HI);
        assign hit_b  = (cnt >= B_LO) && (cnt < B_HI);
        assign win[g] = active && (hit_a || hit_b);
    end

endmodule

// File: rtl/seq2_fsm.sv
module seq2_fsm
    import seq2_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    p1_last,
    input  logic    p2_last,
    output seq_st_e st,
    output logic    p1_done,
    output logic    p2_done,
    output logic    p1_clr
);

    typedef struct packed {
        seq_st_e st;
        logic    d1;
        logic    d2;
    } fsm_s;

    fsm_s fsm_d, fsm_q;

    always_comb begin
        fsm_d  = fsm_q;
        p1_clr = 1'b0;
        case (fsm_q.st)
            ST_RST: fsm_d.st = ST_PH1;
            ST_PH1: begin
                if (p1_last) begin
                    fsm_d.st = ST_PH2;
                    fsm_d.d1 = 1'b1;
                    p1_clr   = 1'b1;
                end
            end
            ST_PH2: begin
                if (p2_last) begin
                    fsm_d.st = ST_END;
                    fsm_d.d2 = 1'b1;
                end
            end
            ST_END:  fsm_d.st = ST_END;
            default: fsm_d.st = ST_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q <= '{st: ST_RST, d1: 1'b0, d2: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign st      = fsm_q.st;
    assign p1_done = fsm_q.d1;
    assign p2_done = fsm_q.d2;

    // R2
    leave_rst_chk: assert property (@(posedge clk) disable iff (rst)
        (fsm_q.st == ST_RST) |=> (fsm_q.st == ST_PH1));

    // R5
    ph1_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (fsm_q.st == ST_PH1 && !p1_last) |=> (fsm_q.st == ST_PH1));

    // R5
    ph2_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        (fsm_q.st == ST_PH2) |-> fsm_q.d1);

    // R7
    end_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fsm_q.st == ST_END) |=> (fsm_q.st == ST_END && fsm_q.d1 && fsm_q.d2));

endmodule

// File: rtl/seq2_ctrl.sv
module seq2_ctrl
    import seq2_pkg::*;
#(
    parameter int unsigned TICKS_PER_UNIT = 50
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    output logic [P1_NOUT-1:0] p1_out,
    output logic [P2_NOUT-1:0] p2_out,
    output logic               p1_done,
    output logic               p2_done,
    output logic [1:0]         state
);

    localparam int unsigned P1_FINAL = P1_UNITS * TICKS_PER_UNIT;
    localparam int unsigned P2_FINAL = P2_UNITS * TICKS_PER_UNIT;
    localparam int unsigned MAX_FIN  = (P1_FINAL > P2_FINAL) ? P1_FINAL : P2_FINAL;
    localparam int unsigned CW       = $clog2(MAX_FIN + 1);

    seq_st_e       st_w;
    logic          p1_clr_w;
    logic          p1_last_w;
    logic          p2_last_w;
    logic [CW-1:0] cnt1_w;
    logic [CW-1:0] cnt2_w;
    logic          ph1_act;
    logic          ph2_act;

    assign ph1_act = (st_w == ST_PH1);
    assign ph2_act = (st_w == ST_PH2);

    seq2_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .p1_last (p1_last_w),
        .p2_last (p2_last_w),
        .st      (st_w),
        .p1_done (p1_done),
        .p2_done (p2_done),
        .p1_clr  (p1_clr_w)
    );

    seq2_count #(.CW(CW), .FINAL(P1_FINAL)) u_cnt1 (
        .clk  (clk),
        .rst  (rst),
        .en   (run && ph1_act),
        .clr  (p1_clr_w),
        .cnt  (cnt1_w),
        .last (p1_last_w)
    );

    seq2_count #(.CW(CW), .FINAL(P2_FINAL)) u_cnt2 (
        .clk  (clk),
        .rst  (rst),
        .en   (run && ph2_act),
        .clr  (1'b0),
        .cnt  (cnt2_w),
        .last (p2_last_w)
    );

    seq2_window #(
        .NOUT (P1_NOUT), .TPU (TICKS_PER_UNIT), .CW (CW),
        .LO_A (P1_LO_A), .HI_A (P1_HI_A), .LO_B (P1_LO_B), .HI_B (P1_HI_B)
    ) u_win1 (
        .active (ph1_act),
        .cnt    (cnt1_w),
        .win    (p1_out)
    );

    seq2_window #(
        .NOUT (P2_NOUT), .TPU (TICKS_PER_UNIT), .CW (CW),
        .LO_A (P2_LO_A), .HI_A (P2_HI_A), .LO_B (P2_LO_B), .HI_B (P2_HI_B)
    ) u_win2 (
        .active (ph2_act),
        .cnt    (cnt2_w),
        .win    (p2_out)
    );

    assign state = st_w;

    // R8
    p1_off_chk: assert property (@(posedge clk) disable iff (rst)
        (state != 2'd1) |-> (p1_out == '0));

    // R8
    p2_off_chk: assert property (@(posedge clk) disable iff (rst)
        (state != 2'd2) |-> (p2_out == '0));

    // R6
    p2_from_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (st_w == ST_PH1 && p1_clr_w) |=> (cnt2_w == '0 && cnt1_w == '0));

endmodule

// File: tb/sim_seq2_ctrl.sv
`timescale 1ns/1ps
module sim_seq2_ctrl;

    localparam int F = 3;
    localparam int B_LO_A [8] = '{1, 1, 1, 11, 1, 1, 1, 2};
    localparam int B_HI_A [8] = '{10, 17, 9, 16, 18, 5, 5, 9};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic [7:0] p1_out;
    logic [2:0] p2_out;
    logic       p1_done, p2_done;
    logic [1:0] state;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit chk_on = 1'b0;

    int m_st = 0, m_c1 = 0, m_c2 = 0;
    bit m_d1 = 1'b0, m_d2 = 1'b0;

    seq2_ctrl #(.TICKS_PER_UNIT(F)) u0 (
        .clk(clk), .rst(rst), .run(run),
        .p1_out(p1_out), .p2_out(p2_out),
        .p1_done(p1_done), .p2_done(p2_done), .state(state)
    );

    always #10 clk = ~clk;

    function automatic int exp_p1(int c);
        int v = 0;
        for (int i = 0; i < 8; i++) begin
            if (c >= B_LO_A[i] * F && c < B_HI_A[i] * F) v |= (1 << i);
        end
        if (c >= 13 * F && c < 17 * F) v |= (1 << 7);
        return v;
    endfunction

    function automatic int exp_p2(int c);
        return (c >= F && c < 8 * F) ? 7 : 0;
    endfunction

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d exp %0d", tag, got, exp);
        end
    endtask

    // reference model written from the requirements
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m_st <= 0; m_c1 <= 0; m_c2 <= 0; m_d1 <= 0; m_d2 <= 0;
        end else begin
            case (m_st)
                0: m_st <= 1;
                1: if (m_c1 == 18 * F) begin
                       m_st <= 2; m_c1 <= 0; m_d1 <= 1;
                   end else if (run) m_c1 <= m_c1 + 1;
                2: if (m_c2 == 8 * F) begin
                       m_st <= 3; m_d2 <= 1;
                   end else if (run) m_c2 <= m_c2 + 1;
                default: m_st <= 3;
            endcase
        end
    end

    always @(negedge clk) begin
        if (chk_on) begin
            check("R2 R5 R7 state", int'(state), m_st);
            check(m_st == 1 ? "R3 R4 p1_out" : "R8 p1_out", int'(p1_out),
                  m_st == 1 ? exp_p1(m_c1) : 0);
            check(m_st == 2 ? "R3 R6 p2_out" : "R8 p2_out", int'(p2_out),
                  m_st == 2 ? exp_p2(m_c2) : 0);
            check("R5 p1_done", int'(p1_done), int'(m_d1));
            check("R7 p2_done", int'(p2_done), int'(m_d2));
        end
    end

    always @(posedge clk) begin
        if (cyc > 5000) begin
            errors++;
            $display("FAIL watchdog got %0d cycles exp under 5000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_state(int s, output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (int'(state) != s && k < 1000);
    endtask

    task automatic check_reset_state();
        check("R1 state", int'(state), 0);
        check("R1 outs", int'({p1_out, p2_out}), 0);
        check("R1 done", int'({p1_done, p2_done}), 0);
    endtask

    initial begin
        int k;
        repeat (3) @(negedge clk);
        check_reset_state();
        chk_on = 1'b1;

        // full run with run held high
        rst = 1'b0; run = 1'b1;
        wait_state(2, k);
        check("R5 edges to phase two", k, 18 * F + 2);
        begin
            int k2;
            wait_state(3, k2);
            check("R7 edges to end", k + k2, 26 * F + 3);
        end
        repeat (20) @(negedge clk);
        check("R7 end holds", int'(state), 3);

        // reset from end, then a run with pauses
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        for (int n = 0; n < 600 && int'(state) != 3; n++) begin
            run = (n % 3 != 2);
            @(negedge clk);
        end
        check("R3 paused run ends", int'(state), 3);

        // reset in the middle of phase two, then restart
        rst = 1'b1; @(negedge clk); rst = 1'b0; run = 1'b1;
        wait_state(2, k);
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        wait_state(2, k);
        check("R9 restart edges to phase two", k, 18 * F + 2);

        // leave reset with run low
        rst = 1'b1; run = 1'b0; @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        check("R2 phase one with run low", int'(state), 1);
        check("R3 lines idle at count zero", int'(p1_out), 0);
        run = 1'b1;
        wait_state(2, k);
        check("R3 edges after unpause", k, 18 * F + 1);
        wait_state(3, k);
        check("R7 end after unpause", k, 8 * F + 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule